// File: doc/BRIEF.md
# Mixed-Edge External Interrupt Detector

This block takes a group of asynchronous request pins and turns qualified transitions on them into per-source pending flags. Every pin passes through a two-flop synchronizer and then a glitch filter. The filter accepts a new level only after the level has held for a set number of clock cycles. Each source then applies its own edge policy to the accepted changes:

- two vectored sources have a rising/falling choice set by software;
- one polling-only source reacts to rising changes;
- one vectored source reacts to both directions;
- a bank of key-scan sources reacts to falling changes only.

Software uses a small write port for three things: choosing the edge of the selectable sources, setting per-source enables, and clearing pending flags. The block drives a single request line toward the CPU. Only the vectored sources can raise it. The polling-only sources just leave a pending flag for software to read.

The source index order is fixed:

| Index | Source | Edge policy | Vectored |
|---|---|---|---|
| 0 to NUM_SEL-1 | selectable sources | rising or falling, per software | yes |
| NUM_SEL | rise-only source | rising | no |
| NUM_SEL+1 | dual-edge source | rising and falling | yes |
| NUM_SEL+2 upward | key sources | falling | no |

With the default parameters the indices are 0 and 1 (selectable), 2 (rise-only), 3 (dual-edge) and 4 to 11 (keys 0 to 7). The synchronizer and the filtered level leave reset at logic high, which is the idle level of the pins.

Top module: `ext_irq_edge_detect`

## Requirements
- R1: After reset every pending flag reads 0 and `irq_o` is 0.
- R2: A pin change is accepted only after the synchronized level has differed from the filtered level for FILT_CYCLES consecutive clock edges. A clean change made between two edges shows on `pending_o` right after the (FILT_CYCLES+2)th rising edge, and not after the one before it.
- R3: A pulse lasting FILT_CYCLES-1 clock cycles leaves no pending flag. A pulse lasting FILT_CYCLES cycles is accepted.
- R4: Bit i of the edge register (address 0, `wr_data_i[i]`) sets the edge of selectable source i. The value 0 means rising and 1 means falling, and the reset value is 0. The edge that is not selected sets nothing.
- R5: The rise-only source sets its pending flag on rising changes and ignores falling ones.
- R6: The dual-edge source sets its pending flag on both rising and falling changes.
- R7: Each key source (pending bit NUM_SEL+2+k for key k) sets on falling changes only.
- R8: A write to address 2 clears every pending bit where `wr_data_i` holds 1 and leaves the other bits unchanged.
- R9: If a qualified edge and a clear of the same bit land on the same clock edge, the bit ends up set.
- R10: `irq_o` is the OR of pending AND enabled over the vectored sources. The enable register is at address 1, with bit i enabling source i, and resets to 0.
- R11: Pending flags of the rise-only and key sources never assert `irq_o`, whatever their enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_pin_i | input | NUM_SEL | Pins of the selectable-edge vectored sources |
| rise_pin_i | input | 1 | Pin of the rise-only polling source |
| dual_pin_i | input | 1 | Pin of the dual-edge vectored source |
| key_pin_i | input | NUM_KEYS | Key-scan pins, falling edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 edge select, 1 enable, 2 clear |
| wr_data_i | input | NUM_SRC | Write data, one bit per source |
| pending_o | output | NUM_SRC | Pending flags in source index order |
| irq_o | output | 1 | Request toward the CPU |

## Verification
The bench drives each pin group with a falling step and then a rising step. This separates the four edge policies: a wrong policy shows up as a flag on the step that should be ignored, or a missing flag on the step that should count. The selectable sources are run in both edge settings. Pulses one cycle shorter than the filter window, and pulses exactly as long as it, show whether the acceptance count is off by one. The latency is checked on the exact edge, and a clear is timed onto the same edge as a set, so that set-versus-clear priority is observed directly. Enable patterns are combined with pending polling-only sources, to show that only vectored sources reach the request line.

// File: rtl/ext_irq_pkg.sv
// Package: shared register address codes for the interrupt edge detector.
package ext_irq_pkg;

    // Register selector on the write port.
    typedef enum logic [1:0] {
        REG_EDGE  = 2'd0,
        REG_EN    = 2'd1,
        REG_CLR   = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ext_irq_sync_filter.sv
// Module: ext_irq_sync_filter
// Synchronizes one asynchronous pin with two flops, then accepts a new level
// only after it has differed from the filtered level for FILT_CYCLES
// consecutive clocks. Emits one-cycle rise/fall strobes on acceptance.
// Assumes the pin idles at IDLE_LEVEL while reset is applied.
module ext_irq_sync_filter #(
    parameter int FILT_CYCLES = 1000,
    parameter bit IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] run_q;
    logic          differ;
    logic          accept;

    assign differ = (sync_q != level_o);
    assign accept = differ && (run_q == CW'(FILT_CYCLES - 1));
    assign rise_o = accept &  sync_q;
    assign fall_o = accept & ~sync_q;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE_LEVEL;
            sync_q <= IDLE_LEVEL;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Count consecutive cycles of disagreement; restart on agreement or acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!differ || accept) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Filtered level follows the synchronized pin once the change is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= IDLE_LEVEL;
        end else if (accept) begin
            level_o <= sync_q;
        end
    end

endmodule

// File: rtl/ext_irq_edge_policy.sv
// Module: ext_irq_edge_policy
// Maps accepted rise/fall strobes to per-source hits according to the fixed
// index layout: selectable sources, then rise-only, then dual-edge, then keys.
// Purely combinational; assumes at most one strobe per source per cycle.
module ext_irq_edge_policy #(
    parameter int NUM_SEL  = 2,
    parameter int NUM_KEYS = 8,
    localparam int NUM_SRC = NUM_SEL + 2 + NUM_KEYS
) (
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [NUM_SRC-1:0] fall_i,
    input  logic [NUM_SEL-1:0] edge_sel_i,
    output logic [NUM_SRC-1:0] hit_o
);
    localparam int RISE_IDX = NUM_SEL;
    localparam int DUAL_IDX = NUM_SEL + 1;

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_src
            if (i < NUM_SEL) begin : g_sel
                // Selectable source: 0 picks rising, 1 picks falling.
                assign hit_o[i] = edge_sel_i[i] ? fall_i[i] : rise_i[i];
            end else if (i == RISE_IDX) begin : g_rise
                // Rise-only polling source.
                assign hit_o[i] = rise_i[i];
            end else if (i == DUAL_IDX) begin : g_dual
                // Dual-edge source.
                assign hit_o[i] = rise_i[i] | fall_i[i];
            end else begin : g_key
                // Key-scan source: falling only.
                assign hit_o[i] = fall_i[i];
            end
        end
    endgenerate

endmodule

// File: rtl/ext_irq_pend_regs.sv
// Module: ext_irq_pend_regs
// Holds the edge-select and enable registers and the pending flags, and forms
// the request line from the vectored sources. A set on the same edge as a
// clear leaves the flag set.
module ext_irq_pend_regs #(
    parameter int NUM_SEL  = 2,
    parameter int NUM_KEYS = 8,
    localparam int NUM_SRC = NUM_SEL + 2 + NUM_KEYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic [NUM_SRC-1:0] hit_i,
    output logic [NUM_SEL-1:0] edge_sel_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               irq_o
);
    import ext_irq_pkg::*;

    localparam logic [NUM_SRC-1:0] VEC_MASK =
        {{NUM_KEYS{1'b0}}, 1'b1, 1'b0, {NUM_SEL{1'b1}}};

    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] clr_mask;

    assign clr_mask = (wr_en_i && wr_addr_i == REG_CLR) ? wr_data_i : '0;

    // Edge-select register for the selectable sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel_o <= '0;
        end else if (wr_en_i && wr_addr_i == REG_EDGE) begin
            edge_sel_o <= wr_data_i[NUM_SEL-1:0];
        end
    end

    // Per-source enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_en_i && wr_addr_i == REG_EN) begin
            enable_q <= wr_data_i;
        end
    end

    // Pending flags: clear by write, set by hit, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= '0;
        end else begin
            pending_o <= (pending_o & ~clr_mask) | hit_i;
        end
    end

    // Request line from enabled vectored sources only.
    always_comb begin
        irq_o = |(pending_o & enable_q & VEC_MASK);
    end

endmodule

// File: rtl/ext_irq_edge_detect.sv
// Module: ext_irq_edge_detect (top)
// Filters every request pin, applies per-group edge policies and latches
// pending flags. Pins are assumed idle-high during reset. Source order:
// selectable [0..NUM_SEL-1], rise-only, dual-edge, keys.
module ext_irq_edge_detect #(
    parameter int NUM_SEL     = 2,
    parameter int NUM_KEYS    = 8,
    parameter int FILT_CYCLES = 1000,
    localparam int NUM_SRC    = NUM_SEL + 2 + NUM_KEYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SEL-1:0]  sel_pin_i,
    input  logic                rise_pin_i,
    input  logic                dual_pin_i,
    input  logic [NUM_KEYS-1:0] key_pin_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [NUM_SRC-1:0]  wr_data_i,
    output logic [NUM_SRC-1:0]  pending_o,
    output logic                irq_o
);
    logic [NUM_SRC-1:0] raw_pins;
    logic [NUM_SRC-1:0] src_level;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] src_fall;
    logic [NUM_SRC-1:0] src_hit;
    logic [NUM_SEL-1:0] edge_sel;

    assign raw_pins = {key_pin_i, dual_pin_i, rise_pin_i, sel_pin_i};

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_filt
            ext_irq_sync_filter #(
                .FILT_CYCLES (FILT_CYCLES),
                .IDLE_LEVEL  (1'b1)
            ) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (raw_pins[i]),
                .level_o (src_level[i]),
                .rise_o  (src_rise[i]),
                .fall_o  (src_fall[i])
            );
        end
    endgenerate

    ext_irq_edge_policy #(
        .NUM_SEL  (NUM_SEL),
        .NUM_KEYS (NUM_KEYS)
    ) u_policy (
        .rise_i     (src_rise),
        .fall_i     (src_fall),
        .edge_sel_i (edge_sel),
        .hit_o      (src_hit)
    );

    ext_irq_pend_regs #(
        .NUM_SEL  (NUM_SEL),
        .NUM_KEYS (NUM_KEYS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .hit_i      (src_hit),
        .edge_sel_o (edge_sel),
        .pending_o  (pending_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/ext_irq_edge_detect_chk.sv
// Module: ext_irq_edge_detect_chk
// Temporal checks on the edge detector, attached to the top through bind.
module ext_irq_edge_detect_chk #(
    parameter int NUM_SEL  = 2,
    parameter int NUM_KEYS = 8,
    localparam int NUM_SRC = NUM_SEL + 2 + NUM_KEYS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic [1:0]         wr_addr_i,
    input logic [NUM_SRC-1:0] wr_data_i,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] fall,
    input logic [NUM_SRC-1:0] hit,
    input logic [NUM_SRC-1:0] pending_o,
    input logic               irq_o
);
    localparam logic [NUM_SRC-1:0] VEC_MASK =
        {{NUM_KEYS{1'b0}}, 1'b1, 1'b0, {NUM_SEL{1'b1}}};
    localparam logic [NUM_SRC-1:0] KEY_MASK =
        {{NUM_KEYS{1'b1}}, 2'b00, {NUM_SEL{1'b0}}};

    // A filtered change is one direction at a time.
    p_one_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & fall) == '0);

    // A flag may only appear after a qualified hit.
    p_set_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_o & ~$past(pending_o)) & ~$past(hit)) == '0);

    // Keys only ever hit on falling changes.
    p_key_falling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & KEY_MASK & ~fall) == '0);

    // A clear write empties the selected bits unless a hit coincides.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd2) |=> (pending_o & $past(wr_data_i & ~hit)) == '0);

    // A hit on the clear edge leaves the flag set.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd2 && (wr_data_i & hit) != '0)
        |=> (pending_o & $past(wr_data_i & hit)) == $past(wr_data_i & hit));

    // Without vectored pending flags the request stays low.
    p_quasi_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_o & VEC_MASK) == '0) |-> !irq_o);

endmodule

bind ext_irq_edge_detect ext_irq_edge_detect_chk #(
    .NUM_SEL  (NUM_SEL),
    .NUM_KEYS (NUM_KEYS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rise      (src_rise),
    .fall      (src_fall),
    .hit       (src_hit),
    .pending_o (pending_o),
    .irq_o     (irq_o)
);

// File: tb/ext_irq_edge_detect_tb.sv
`timescale 1ns/1ps
// Directed bench for ext_irq_edge_detect: one task per scenario.
module ext_irq_edge_detect_tb;
    localparam int F  = 4;
    localparam int NS = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel_pin = 2'b11;
    logic          rise_pin = 1'b1;
    logic          dual_pin = 1'b1;
    logic [7:0]    key_pin = 8'hFF;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [NS-1:0] wr_data = '0;
    logic [NS-1:0] pending;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    ext_irq_edge_detect #(.NUM_SEL(2), .NUM_KEYS(8), .FILT_CYCLES(F)) u_dut (
        .clk (clk), .rst_n (rst_n), .sel_pin_i (sel_pin), .rise_pin_i (rise_pin),
        .dual_pin_i (dual_pin), .key_pin_i (key_pin), .wr_en_i (wr_en),
        .wr_addr_i (wr_addr), .wr_data_i (wr_data), .pending_o (pending), .irq_o (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        wr(2'd2, '1);
    endtask

    task automatic t_reset();
        edges(2);
        check("R1 pending", 32'(pending), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_sel_rising();
        @(negedge clk); sel_pin[0] = 1'b0;
        edges(F + 3);
        check("R4 falling ignored in rising mode", 32'(pending), 32'h0);
        @(negedge clk); sel_pin[0] = 1'b1;
        edges(F + 1);
        check("R2 not yet accepted", 32'(pending), 32'h0);
        edges(1);
        check("R2 accepted on edge F+2", 32'(pending), 32'h001);
        wr(2'd2, 12'h002);
        check("R8 zero bits untouched", 32'(pending), 32'h001);
        wr(2'd2, 12'h001);
        check("R8 bit cleared", 32'(pending), 32'h0);
    endtask

    task automatic t_sel_falling();
        wr(2'd0, 12'h002);
        @(negedge clk); sel_pin[1] = 1'b0;
        edges(F + 2);
        check("R4 falling mode sets", 32'(pending), 32'h002);
        clear_all();
        @(negedge clk); sel_pin[1] = 1'b1;
        edges(F + 3);
        check("R4 rising ignored in falling mode", 32'(pending), 32'h0);
    endtask

    task automatic t_rise_only();
        @(negedge clk); rise_pin = 1'b0;
        edges(F + 3);
        check("R5 falling ignored", 32'(pending), 32'h0);
        @(negedge clk); rise_pin = 1'b1;
        edges(F + 2);
        check("R5 rising sets", 32'(pending), 32'h004);
        clear_all();
    endtask

    task automatic t_dual();
        @(negedge clk); dual_pin = 1'b0;
        edges(F + 2);
        check("R6 falling sets", 32'(pending), 32'h008);
        clear_all();
        @(negedge clk); dual_pin = 1'b1;
        edges(F + 2);
        check("R6 rising sets", 32'(pending), 32'h008);
        clear_all();
    endtask

    task automatic t_keys();
        @(negedge clk); key_pin[3] = 1'b0;
        edges(F + 2);
        check("R7 key3 falling", 32'(pending), 32'h080);
        @(negedge clk); key_pin[0] = 1'b0; key_pin[7] = 1'b0;
        edges(F + 2);
        check("R7 keys 0 and 7 falling", 32'(pending), 32'h890);
        clear_all();
        @(negedge clk); key_pin = 8'hFF;
        edges(F + 3);
        check("R7 rising ignored", 32'(pending), 32'h0);
    endtask

    task automatic t_filter();
        @(negedge clk); dual_pin = 1'b0;
        repeat (F - 1) @(negedge clk);
        dual_pin = 1'b1;
        edges(F + 4);
        check("R3 short pulse rejected", 32'(pending), 32'h0);
        @(negedge clk); dual_pin = 1'b0;
        repeat (F) @(negedge clk);
        dual_pin = 1'b1;
        edges(F + 4);
        check("R3 full-width pulse accepted", 32'(pending), 32'h008);
        clear_all();
    endtask

    task automatic t_irq();
        wr(2'd1, '1);
        @(negedge clk); key_pin[1] = 1'b0; rise_pin = 1'b0;
        edges(F + 2);
        check("R11 key pending", 32'(pending), 32'h020);
        check("R11 quasi sources keep irq low", 32'(irq), 32'h0);
        @(negedge clk); rise_pin = 1'b1;
        edges(F + 2);
        check("R11 rise-only pending, irq low", 32'({pending, irq}), 32'({12'h024, 1'b0}));
        clear_all();
        @(negedge clk); dual_pin = 1'b0;
        edges(F + 2);
        check("R10 vectored enabled raises irq", 32'(irq), 32'h1);
        wr(2'd1, ~12'h008);
        check("R10 disabled source drops irq", 32'(irq), 32'h0);
        check("R10 pending kept when disabled", 32'(pending), 32'h008);
        wr(2'd1, '1);
        check("R10 re-enable raises irq", 32'(irq), 32'h1);
        clear_all();
        check("R10 cleared drops irq", 32'(irq), 32'h0);
        @(negedge clk); key_pin[1] = 1'b1; dual_pin = 1'b1;
        edges(F + 3);
        clear_all();
    endtask

    task automatic t_set_wins();
        @(negedge clk); dual_pin = 1'b0;
        repeat (F + 1) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 12'h008;
        edges(1);
        check("R9 set beats clear", 32'(pending), 32'h008);
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        clear_all();
        check("R8 later clear works", 32'(pending), 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_sel_rising();
        t_sel_falling();
        t_rise_only();
        t_dual();
        t_keys();
        t_filter();
        t_irq();
        t_set_wins();
        summary();
    end

endmodule